// File: doc/BRIEF.md
# I2C Target Event Engine

This block is the target (slave) side of an I2C bus for 7-bit addressing. It is built to sit beside a small processor. The block filters the SCL and SDA inputs and finds START, repeated START and STOP conditions. It shifts address and data bytes in and out, and it answers each byte with an ACK or a NACK on the ninth clock.

The block does not stream bytes on its own. After every bus event it does three things:
- raises an event flag,
- puts a 4-bit status code on its status port,
- holds SCL low when the bus clock is low, for as long as the flag stays up.

The host reads the status. It takes the received byte from the read port, or writes the next byte to send. It then pulses a clear input. Clearing the flag releases SCL, and the transfer goes on.

The host sets several inputs: the own address, an address mask, a general-call enable and an ACK-enable. No bit-rate setting exists. The system clock must run at least 16 times faster than SCL. The pads are modelled as open drain: each output-enable pulls its line low when high.

Top module: `i2c_evt_slave`

## Requirements
- R1: A START or repeated START is a high-to-low SDA change while SCL is high. After one, the engine receives 7 address bits MSB first, then a direction bit (1 means the controller reads). A STOP is a low-to-high SDA change while SCL is high, and it returns the engine to idle.
- R2: The engine ACKs an address that matches the own address while ACK-enable is set. It drives SDA low during the ninth clock. After the ninth falling edge it raises the flag with status 1 for a write or status 2 for a read. Any other address gets a NACK and no flag.
- R3: Address bits whose addr_mask bit is 1 are left out of the own-address compare.
- R4: Address 0 with a write direction is answered, with status 3, only when gc_en is 1. With gc_en at 0 it gets a NACK and no flag.
- R5: While ack_en is 0, every address byte gets a NACK and raises no flag.
- R6: While the flag is set, the engine holds SCL low once SCL is low. The flag stays set until evt_clr is pulsed. The status reads 0 whenever the flag is clear.
- R7: A data byte written by the controller appears on rd_data. With ack_en set, the byte is ACKed with status 4. With ack_en clear, it is NACKed with status 5 and the rest of the transfer is ignored.
- R8: In a read, the byte on wr_data is sent MSB first after the flag is cleared. A controller ACK gives status 6. A controller NACK gives status 7, and SDA is then left released until the next STOP or START.
- R9: A STOP or repeated START seen while addressed raises the flag with status 8.
- R10: A START or STOP that arrives after two or more bits of a data byte, while addressed, is a bus error. It raises status 9, releases both lines and sends the engine to idle, so it ignores the bus until the next START.
- R11: The engine drives SCL only to stretch it. It starts driving SDA low only while SCL is low.
- R12: After reset the flag is 0, the status is 0 and neither line is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| own_addr | input | 7 | Own target address |
| addr_mask | input | 7 | 1 = ignore this address bit |
| gc_en | input | 1 | Answer the general-call address |
| ack_en | input | 1 | Allow ACK of addresses and data |
| wr_en | input | 1 | Load wr_data into the transmit byte |
| wr_data | input | 8 | Next byte to send |
| rd_data | output | 8 | Last byte received |
| evt_clr | input | 1 | Clear the event flag and release SCL |
| evt_flag | output | 1 | Bus event pending |
| status | output | 4 | Code of the pending event |

## Verification
The bound checker watches the flag handshake on every cycle. It checks that the flag holds until it is cleared and drops on a clear. It checks that the status is zero while the flag is down, and that each rising flag carries a valid event code. It also checks that SDA is never first pulled low while SCL is high.

Other behaviour can only be shown by the directed scenarios, which drive a controller model onto the wired bus:
- whether a given address, mask or general-call setting earns an ACK;
- the byte values moved in each direction;
- stretching against a released controller clock;
- the split between a legal repeated START and a bus error, which depends on how many bits of the byte were shifted;
- recovery after a bus error.

// File: rtl/i2c_evt_slave.sv
`timescale 1ns/1ps
module i2c_evt_slave #(
  parameter int FILT = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe,
  output logic       sda_oe,
  input  logic [6:0] own_addr,
  input  logic [6:0] addr_mask,
  input  logic       gc_en,
  input  logic       ack_en,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       evt_clr,
  output logic       evt_flag,
  output logic [3:0] status
);
  localparam int HALF = FILT / 2;
  localparam logic [3:0] C_IDLE = 4'd0, C_SLAW = 4'd1, C_SLAR = 4'd2, C_GC = 4'd3,
                         C_RACK = 4'd4, C_RNAK = 4'd5, C_TACK = 4'd6, C_TNAK = 4'd7,
                         C_STOP = 4'd8, C_BERR = 4'd9;

  typedef enum logic [2:0] {ST_IDLE, ST_ADDR, ST_RX, ST_TX, ST_WAIT} st_t;

  logic [1:0] scl_sy, sda_sy;
  logic [FILT-1:0] scl_w, sda_w;
  logic scl_f, sda_f, scl_q, sda_q, scl_hold;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= '1; sda_sy <= '1; scl_w <= '1; sda_w <= '1;
      scl_f <= 1'b1; sda_f <= 1'b1; scl_q <= 1'b1; sda_q <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_w  <= {scl_w[FILT-2:0], scl_sy[1]};
      sda_w  <= {sda_w[FILT-2:0], sda_sy[1]};
      scl_f  <= $countones(scl_w) > HALF;
      sda_f  <= $countones(sda_w) > HALF;
      scl_q  <= scl_f;
      sda_q  <= sda_f;
    end

  wire scl_rise = scl_f & ~scl_q;
  wire scl_fall = ~scl_f & scl_q;
  wire start_c  = scl_f & scl_q & sda_q & ~sda_f;
  wire stop_c   = scl_f & scl_q & ~sda_q & sda_f;

  st_t        st;
  logic [3:0] bitcnt, pend;
  logic [7:0] shreg, tx_byte;
  logic       addressed, sda_drv;

  wire [6:0] adr      = shreg[7:1];
  wire       gc_hit   = gc_en && adr == 7'd0 && !shreg[0];
  wire       own_hit  = adr != 7'd0 && ((adr ^ own_addr) & ~addr_mask) == 7'd0;
  wire       mid_byte = addressed && (st == ST_RX || st == ST_TX) && bitcnt >= 4'd2;
  wire       shifting = st == ST_ADDR || st == ST_RX || st == ST_TX;
  wire [7:0] tx_next  = wr_en ? wr_data : tx_byte;

  assign sda_oe = sda_drv;
  assign scl_oe = scl_hold;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) scl_hold <= 1'b0;
    else        scl_hold <= evt_flag & ~scl_f;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= ST_IDLE; bitcnt <= '0; pend <= C_IDLE; shreg <= '0; tx_byte <= '0;
      rd_data <= '0; addressed <= 1'b0; sda_drv <= 1'b0; evt_flag <= 1'b0; status <= C_IDLE;
    end else begin
      if (wr_en) tx_byte <= wr_data;
      if (evt_clr && evt_flag) begin
        evt_flag <= 1'b0;
        status   <= C_IDLE;
        if (st == ST_TX) begin
          shreg   <= tx_next;
          sda_drv <= ~tx_next[7];
        end
      end
      if (start_c || stop_c) begin
        bitcnt  <= '0;
        sda_drv <= 1'b0;
        addressed <= 1'b0;
        if (mid_byte) begin
          evt_flag <= 1'b1; status <= C_BERR; st <= ST_IDLE;
        end else begin
          if (addressed) begin evt_flag <= 1'b1; status <= C_STOP; end
          st <= start_c ? ST_ADDR : ST_IDLE;
        end
      end else if (scl_rise && shifting) begin
        if (bitcnt < 4'd8 && st != ST_TX) shreg <= {shreg[6:0], sda_f};
        if (st == ST_TX && bitcnt == 4'd8) pend <= sda_f ? C_TNAK : C_TACK;
        bitcnt <= bitcnt + 4'd1;
      end else if (scl_fall && shifting) begin
        case (bitcnt)
          4'd8: begin
            if (st == ST_ADDR) begin
              if (ack_en && (own_hit || gc_hit)) begin
                sda_drv <= 1'b1;
                pend    <= gc_hit ? C_GC : (shreg[0] ? C_SLAR : C_SLAW);
              end else begin
                st <= ST_WAIT; bitcnt <= '0;
              end
            end else if (st == ST_RX) begin
              rd_data <= shreg;
              sda_drv <= ack_en;
              pend    <= ack_en ? C_RACK : C_RNAK;
            end else begin
              sda_drv <= 1'b0;
            end
          end
          4'd9: begin
            sda_drv   <= 1'b0;
            bitcnt    <= '0;
            evt_flag  <= 1'b1;
            status    <= pend;
            addressed <= 1'b1;
            if (pend == C_SLAR || pend == C_TACK) st <= ST_TX;
            else if (pend == C_RNAK || pend == C_TNAK) st <= ST_WAIT;
            else st <= ST_RX;
          end
          default: begin
            if (st == ST_TX && bitcnt != 4'd0) begin
              sda_drv <= ~shreg[6];
              shreg   <= {shreg[6:0], 1'b0};
            end
          end
        endcase
      end
    end
endmodule

module i2c_evt_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       sda_oe,
  input logic       scl_oe,
  input logic       evt_flag,
  input logic       evt_clr,
  input logic [3:0] status
);
  // R6
  hold_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_flag && !evt_clr |=> evt_flag);
  // R6
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_flag && evt_clr |=> !evt_flag);
  // R6
  idle_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_flag |-> status == 4'd0);
  // R2
  event_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_flag) |-> (status != 4'd0 && status <= 4'd9));
  // R11
  sda_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_i);
  // R11
  stretch_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_oe) |-> evt_flag);
endmodule

bind i2c_evt_slave i2c_evt_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe), .scl_oe(scl_oe),
  .evt_flag(evt_flag), .evt_clr(evt_clr), .status(status));

// File: tb/i2c_evt_slave_bench.sv
`timescale 1ns/1ps
module i2c_evt_slave_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, m_scl, m_sda, gc_en, ack_en, wr_en, evt_clr;
  logic [6:0] own_addr, addr_mask;
  logic [7:0] wr_data, rd_data;
  logic scl_oe, sda_oe, evt_flag;
  logic [3:0] status;
  wire scl_bus = m_scl & ~scl_oe;
  wire sda_bus = m_sda & ~sda_oe;

  i2c_evt_slave u_i2c_evt_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .own_addr(own_addr), .addr_mask(addr_mask),
    .gc_en(gc_en), .ack_en(ack_en), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .evt_clr(evt_clr), .evt_flag(evt_flag), .status(status));

  int n_chk = 0, n_fail = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic scl_up;
    m_scl = 1'b1;
    do @(negedge clk); while (!scl_bus);
  endtask

  task automatic put_bit(input logic b);
    m_sda = b; clks(8); scl_up; clks(16); m_scl = 1'b0; clks(8);
  endtask

  task automatic get_bit(output logic b);
    m_sda = 1'b1; clks(8); scl_up; clks(8); b = sda_bus; clks(8); m_scl = 1'b0; clks(8);
  endtask

  task automatic wr_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(b);
    ack = !b;
  endtask

  task automatic rd_byte(input logic mack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) get_bit(d[i]);
    put_bit(!mack);
  endtask

  task automatic bstart;
    m_sda = 1'b1; clks(8); scl_up; clks(8); m_sda = 1'b0; clks(8); m_scl = 1'b0; clks(8);
  endtask

  task automatic bstop;
    m_sda = 1'b0; clks(8); scl_up; clks(8); m_sda = 1'b1; clks(16);
  endtask

  task automatic host_clear;
    @(negedge clk); evt_clr = 1'b1;
    @(negedge clk); evt_clr = 1'b0;
    clks(2);
  endtask

  task automatic host_write(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic expect_evt(input string req, input int code);
    clks(10);
    chk(req, evt_flag, 1);
    chk(req, status, code);
  endtask

  task automatic expect_none(input string req);
    clks(10);
    chk(req, evt_flag, 0);
  endtask

  task automatic t_reset;
    chk("R12 flag", evt_flag, 0);
    chk("R12 status", status, 0);
    chk("R12 sda_oe", sda_oe, 0);
    chk("R12 scl_oe", scl_oe, 0);
  endtask

  task automatic t_write;
    logic ack;
    bstart;
    wr_byte(8'h84, ack);
    chk("R2 ack write addr", ack, 1);
    expect_evt("R2 SLA+W", 1);
    m_scl = 1'b1; clks(6);
    chk("R6 scl stretched", scl_bus, 0);
    m_scl = 1'b0;
    host_clear;
    chk("R6 status idle after clear", status, 0);
    wr_byte(8'hA5, ack);
    chk("R7 data ack", ack, 1);
    expect_evt("R7 rx ack", 4);
    chk("R7 rd_data", rd_data, 8'hA5);
    host_clear;
    bstop;
    expect_evt("R9 stop", 8);
    host_clear;
    chk("R11 scl released", scl_oe, 0);
    chk("R1 sda released idle", sda_oe, 0);
  endtask

  task automatic t_rx_nack;
    logic ack;
    bstart;
    wr_byte(8'h84, ack);
    expect_evt("R2 SLA+W", 1);
    ack_en = 1'b0;
    host_clear;
    wr_byte(8'h3C, ack);
    chk("R7 data nack", ack, 0);
    expect_evt("R7 rx nack", 5);
    chk("R7 rd_data nack", rd_data, 8'h3C);
    ack_en = 1'b1;
    host_clear;
    bstop;
    expect_evt("R9 stop after nack", 8);
    host_clear;
  endtask

  task automatic t_addr_miss;
    logic ack;
    bstart;
    wr_byte(8'h26, ack);
    chk("R2 other addr nack", ack, 0);
    expect_none("R2 other addr no flag");
    bstop;
    expect_none("R1 stop unaddressed");
  endtask

  task automatic t_mask;
    logic ack;
    addr_mask = 7'h03;
    bstart;
    wr_byte(8'h82, ack);
    chk("R3 masked match ack", ack, 1);
    expect_evt("R3 masked match", 1);
    host_clear;
    bstop;
    expect_evt("R9 stop", 8);
    host_clear;
    addr_mask = 7'h00;
    bstart;
    wr_byte(8'h82, ack);
    chk("R3 unmasked miss", ack, 0);
    expect_none("R3 unmasked no flag");
    bstop;
  endtask

  task automatic t_gc;
    logic ack;
    gc_en = 1'b0;
    bstart;
    wr_byte(8'h00, ack);
    chk("R4 gc disabled nack", ack, 0);
    expect_none("R4 gc disabled no flag");
    bstop;
    gc_en = 1'b1;
    bstart;
    wr_byte(8'h00, ack);
    chk("R4 gc ack", ack, 1);
    expect_evt("R4 gc status", 3);
    host_clear;
    wr_byte(8'h55, ack);
    expect_evt("R7 gc data", 4);
    chk("R7 gc rd_data", rd_data, 8'h55);
    host_clear;
    bstop;
    expect_evt("R9 gc stop", 8);
    host_clear;
  endtask

  task automatic t_ack_off;
    logic ack;
    ack_en = 1'b0;
    bstart;
    wr_byte(8'h84, ack);
    chk("R5 ack off nack", ack, 0);
    expect_none("R5 ack off no flag");
    bstop;
    expect_none("R5 ack off stop");
    ack_en = 1'b1;
  endtask

  task automatic t_read;
    logic ack, b;
    logic [7:0] d;
    host_write(8'hC3);
    bstart;
    wr_byte(8'h85, ack);
    chk("R2 read addr ack", ack, 1);
    expect_evt("R2 SLA+R", 2);
    host_clear;
    rd_byte(1'b1, d);
    chk("R8 byte 1", d, 8'hC3);
    expect_evt("R8 tx ack", 6);
    host_write(8'h5A);
    host_clear;
    rd_byte(1'b0, d);
    chk("R8 byte 2", d, 8'h5A);
    expect_evt("R8 tx nack", 7);
    host_clear;
    get_bit(b);
    chk("R8 sda released after nack", b, 1);
    chk("R8 no drive after nack", sda_oe, 0);
    bstop;
    expect_evt("R9 stop after read", 8);
    host_clear;
  endtask

  task automatic t_rstart;
    logic ack;
    logic [7:0] d;
    bstart;
    wr_byte(8'h84, ack);
    expect_evt("R2 SLA+W", 1);
    host_clear;
    wr_byte(8'h11, ack);
    expect_evt("R7 rx", 4);
    host_clear;
    bstart;
    expect_evt("R9 repeated start", 8);
    host_write(8'h7E);
    host_clear;
    wr_byte(8'h85, ack);
    chk("R1 addr after rstart ack", ack, 1);
    expect_evt("R1 SLA+R after rstart", 2);
    host_clear;
    rd_byte(1'b0, d);
    chk("R8 byte after rstart", d, 8'h7E);
    expect_evt("R8 tx nack", 7);
    host_clear;
    bstop;
    expect_evt("R9 stop", 8);
    host_clear;
  endtask

  task automatic t_buserr;
    logic ack;
    bstart;
    wr_byte(8'h84, ack);
    expect_evt("R2 SLA+W", 1);
    host_clear;
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
    bstart;
    expect_evt("R10 bus error", 9);
    host_clear;
    chk("R10 sda released", sda_oe, 0);
    bstop;
    expect_none("R10 idle after error");
    bstart;
    wr_byte(8'h84, ack);
    chk("R10 recovery ack", ack, 1);
    expect_evt("R10 recovery status", 1);
    host_clear;
    bstop;
    expect_evt("R9 stop", 8);
    host_clear;
  endtask

  initial begin
    rst_n = 1'b0; m_scl = 1'b1; m_sda = 1'b1;
    own_addr = 7'h42; addr_mask = 7'h00; gc_en = 1'b0; ack_en = 1'b1;
    wr_en = 1'b0; wr_data = 8'h00; evt_clr = 1'b0;
    clks(5);
    rst_n = 1'b1;
    clks(5);
    t_reset;
    t_write;
    t_rx_nack;
    t_addr_miss;
    t_mask;
    t_gc;
    t_ack_off;
    t_read;
    t_rstart;
    t_buserr;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule